// File: doc/BRIEF.md
# Master Video Sync Generator with Programmable Horizontal Advance

This block is the timing master for a digital video output path. It counts pixel positions along each line and lines within each frame for either a 525-line or a 625-line standard. From those counts it drives three things to a downstream video decoder: a horizontal sync pulse, a vertical sync flag and a field number. The decoder waits for the horizontal pulse and then, after its own fixed pipeline delay, starts placing pixel data on its bus. The block advances while a one-cycle-wide pixel enable is high, and that enable runs at the 13.5 MHz sample rate.

Software writes a 10-bit horizontal offset through two byte-wide writes, one for the upper bits and one for the lower byte. The offset sets where in the line the horizontal pulse begins, so the decoder's first sample lands where it should. A smaller offset moves the pulse earlier. When the requested advance pushes the pulse back past the start of the line, the value wraps into the previous line. A pulse that would run past the end of the line is cut short there.

When master operation is off, the three outputs rest in their inactive state, but the counters keep running. The outputs are therefore consistent again as soon as master operation is turned back on.

Top module: `mst_sync_gen`

## Requirements
- R1: After reset, with master operation on, hs_n is 1, vs_n is 0 (line 0 lies in the vertical interval) and fld is 0.
- R2: A line lasts exactly 858 enabled clocks when std_sel is 0 (525-line) and 864 when std_sel is 1 (625-line). The horizontal pulse repeats with that period.
- R3: hs_n goes low at line position P = offset, or offset minus the line length when the offset is at least the line length. Position 0 is the first enabled clock of a line. hs_n stays low for 64 enabled clocks, and lowering the offset by one moves the pulse one clock earlier. Example: 0x076 gives P=118 and 0x2AC gives P=684 in the 525 standard.
- R4: When P plus 64 exceeds the line length, hs_n returns high at the start of the next line, so the pulse is shorter than 64 clocks.
- R5: The offset resets to 0x07E (pulse at position 126). A write with ofs_hi_we loads ofs_wdata[1:0] into offset bits 9:8. A write with ofs_lo_we loads ofs_wdata[7:0] into offset bits 7:0. Writes take effect on the next clock edge whether or not pix_en is high.
- R6: A frame has FRAME_A (525) or FRAME_B (625) lines, and field two begins at line (frame lines + 1) / 2. vs_n is low for the first VS_LINES (3) lines of each field.
- R7: fld increments by one when a field begins. It wraps from 3 to 0 in the 525 standard and from 7 to 0 in the 625 standard.
- R8: While master_en is 0, hs_n and vs_n are 1 and fld is 0. The counters keep advancing, so turning master_en back on shows the current position at once.
- R9: While pix_en is 0, the line position, line number and field number hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pix_en | input | 1 | Pixel-rate enable, one clock wide |
| master_en | input | 1 | 1 drives the sync outputs; 0 parks them inactive |
| std_sel | input | 1 | 0 = 525-line standard, 1 = 625-line standard (change only in reset) |
| ofs_hi_we | input | 1 | Write enable for offset bits 9:8 |
| ofs_lo_we | input | 1 | Write enable for offset bits 7:0 |
| ofs_wdata | input | 8 | Offset write data |
| hs_n | output | 1 | Horizontal sync, active low |
| vs_n | output | 1 | Vertical sync flag, active low |
| fld | output | 3 | Field number |

## Verification
If the line position is off by even one count, the falling edge of hs_n moves away from its expected position, and this shows on the very next pulse. A wrong wrap or a wrong line length shifts every later pulse, and the error grows with each line. A line number or field number that is wrong shows on vs_n or fld by the next field boundary at the latest. The bench follows the position, line, field and offset with its own model on every clock, so a miscount is reported in the cycle it first reaches a port.

// File: rtl/mst_sync_pkg.sv
package mst_sync_pkg;

  typedef enum logic {
    STD_525 = 1'b0,
    STD_625 = 1'b1
  } vid_std_e;

endpackage

// File: rtl/mst_sync_ofs_reg.sv
module mst_sync_ofs_reg #(
  parameter int              OFS_W = 10,
  parameter int              LO_W  = 8,
  parameter logic [OFS_W-1:0] RST_VAL = 10'h07E
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hi_we,
  input  logic             lo_we,
  input  logic [LO_W-1:0]  wdata,
  output logic [OFS_W-1:0] ofs
);

  localparam int HI_W = OFS_W - LO_W;

  logic [OFS_W-1:0] ofs_d;

  always_comb begin
    ofs_d = ofs;
    if (hi_we) ofs_d[OFS_W-1:LO_W] = wdata[HI_W-1:0];
    if (lo_we) ofs_d[LO_W-1:0]     = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ofs <= RST_VAL;
    else        ofs <= ofs_d;
  end

endmodule

// File: rtl/mst_sync_hcount.sv
module mst_sync_hcount
  import mst_sync_pkg::*;
#(
  parameter int LINE_A   = 858,
  parameter int LINE_B   = 864,
  parameter int OFS_W    = 10,
  parameter int HS_WIDTH = 64,
  parameter int HW       = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pix_en,
  input  vid_std_e         std_sel,
  input  logic [OFS_W-1:0] ofs,
  output logic [HW-1:0]    hcnt,
  output logic             line_end,
  output logic             hs_act
);

  // wide enough for offset, position and position plus pulse width
  localparam int PW = ((OFS_W > HW) ? OFS_W : HW) + 2;

  logic [PW-1:0] len_x, ofs_x, h_x, pos, stop;
  logic [HW-1:0] hcnt_d;

  always_comb begin
    len_x  = (std_sel == STD_625) ? PW'(LINE_B) : PW'(LINE_A);
    ofs_x  = PW'(ofs);
    h_x    = PW'(hcnt);
    // one subtraction suffices: the offset range is below twice the line length
    pos    = (ofs_x >= len_x) ? (ofs_x - len_x) : ofs_x;
    stop   = pos + PW'(HS_WIDTH);
    // h_x never reaches len_x, so a window past the line end is cut there
    hs_act = (h_x >= pos) && (h_x < stop);
  end

  always_comb begin
    line_end = pix_en && (h_x >= (len_x - PW'(1)));
    hcnt_d   = hcnt;
    if (pix_en) hcnt_d = line_end ? '0 : (hcnt + HW'(1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hcnt <= '0;
    else        hcnt <= hcnt_d;
  end

endmodule

// File: rtl/mst_sync_vcount.sv
module mst_sync_vcount
  import mst_sync_pkg::*;
#(
  parameter int FRAME_A  = 525,
  parameter int FRAME_B  = 625,
  parameter int VS_LINES = 3,
  parameter int FLDS_A   = 4,
  parameter int FLDS_B   = 8,
  parameter int FLD_W    = 3,
  parameter int VW       = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             line_end,
  input  vid_std_e         std_sel,
  output logic [VW-1:0]    vcnt,
  output logic             vs_act,
  output logic [FLD_W-1:0] fld
);

  localparam int HALF_A = (FRAME_A + 1) / 2;
  localparam int HALF_B = (FRAME_B + 1) / 2;

  logic [VW-1:0]    last_line, half, vcnt_d;
  logic [FLD_W-1:0] fld_max, fld_d;

  always_comb begin
    last_line = (std_sel == STD_625) ? VW'(FRAME_B - 1) : VW'(FRAME_A - 1);
    half      = (std_sel == STD_625) ? VW'(HALF_B) : VW'(HALF_A);
    fld_max   = (std_sel == STD_625) ? FLD_W'(FLDS_B - 1) : FLD_W'(FLDS_A - 1);
  end

  always_comb begin
    vcnt_d = vcnt;
    fld_d  = fld;
    if (line_end) begin
      vcnt_d = (vcnt >= last_line) ? '0 : (vcnt + VW'(1));
      if ((vcnt_d == '0) || (vcnt_d == half))
        fld_d = (fld >= fld_max) ? '0 : (fld + FLD_W'(1));
    end
  end

  always_comb begin
    vs_act = (vcnt < VW'(VS_LINES)) ||
             ((vcnt >= half) && (vcnt < (half + VW'(VS_LINES))));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vcnt <= '0;
      fld  <= '0;
    end else begin
      vcnt <= vcnt_d;
      fld  <= fld_d;
    end
  end

endmodule

// File: rtl/mst_sync_gen.sv
module mst_sync_gen
  import mst_sync_pkg::*;
#(
  parameter int OFS_W    = 10,
  parameter int LO_W     = 8,
  parameter int OFS_RST  = 'h07E,
  parameter int LINE_A   = 858,
  parameter int LINE_B   = 864,
  parameter int FRAME_A  = 525,
  parameter int FRAME_B  = 625,
  parameter int HS_WIDTH = 64,
  parameter int VS_LINES = 3,
  parameter int FLDS_A   = 4,
  parameter int FLDS_B   = 8,
  parameter int FLD_W    = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pix_en,
  input  logic             master_en,
  input  logic             std_sel,
  input  logic             ofs_hi_we,
  input  logic             ofs_lo_we,
  input  logic [LO_W-1:0]  ofs_wdata,
  output logic             hs_n,
  output logic             vs_n,
  output logic [FLD_W-1:0] fld
);

  localparam int LINE_MAX  = (LINE_A > LINE_B) ? LINE_A : LINE_B;
  localparam int FRAME_MAX = (FRAME_A > FRAME_B) ? FRAME_A : FRAME_B;
  localparam int HW        = $clog2(LINE_MAX);
  localparam int VW        = $clog2(FRAME_MAX);

  logic [1:0]       rst_pipe;
  logic             rst_sync_n;
  vid_std_e         std_e;
  logic [OFS_W-1:0] ofs_q;
  logic [HW-1:0]    hcnt;
  logic [VW-1:0]    vcnt;
  logic [FLD_W-1:0] fld_q;
  logic             line_end, hs_act, vs_act;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  assign std_e = vid_std_e'(std_sel);

  mst_sync_ofs_reg #(
    .OFS_W   (OFS_W),
    .LO_W    (LO_W),
    .RST_VAL (OFS_W'(OFS_RST))
  ) u_ofs (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .hi_we (ofs_hi_we),
    .lo_we (ofs_lo_we),
    .wdata (ofs_wdata),
    .ofs   (ofs_q)
  );

  mst_sync_hcount #(
    .LINE_A   (LINE_A),
    .LINE_B   (LINE_B),
    .OFS_W    (OFS_W),
    .HS_WIDTH (HS_WIDTH),
    .HW       (HW)
  ) u_hcnt (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .pix_en   (pix_en),
    .std_sel  (std_e),
    .ofs      (ofs_q),
    .hcnt     (hcnt),
    .line_end (line_end),
    .hs_act   (hs_act)
  );

  mst_sync_vcount #(
    .FRAME_A  (FRAME_A),
    .FRAME_B  (FRAME_B),
    .VS_LINES (VS_LINES),
    .FLDS_A   (FLDS_A),
    .FLDS_B   (FLDS_B),
    .FLD_W    (FLD_W),
    .VW       (VW)
  ) u_vcnt (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .line_end (line_end),
    .std_sel  (std_e),
    .vcnt     (vcnt),
    .vs_act   (vs_act),
    .fld      (fld_q)
  );

  assign hs_n = ~(hs_act & master_en);
  assign vs_n = ~(vs_act & master_en);
  assign fld  = master_en ? fld_q : '0;

endmodule

// File: rtl/mst_sync_chk.sv
module mst_sync_chk #(
  parameter int OFS_W    = 10,
  parameter int LINE_A   = 858,
  parameter int LINE_B   = 864,
  parameter int FRAME_A  = 525,
  parameter int FRAME_B  = 625,
  parameter int HS_WIDTH = 64,
  parameter int FLD_W    = 3,
  parameter int HW       = 10,
  parameter int VW       = 10
) (
  input logic             clk,
  input logic             rst_sync_n,
  input logic             pix_en,
  input logic             master_en,
  input logic             std_sel,
  input logic             ofs_hi_we,
  input logic             ofs_lo_we,
  input logic [OFS_W-1:0] ofs_q,
  input logic [HW-1:0]    hcnt,
  input logic [VW-1:0]    vcnt,
  input logic [FLD_W-1:0] fld_q,
  input logic             hs_n,
  input logic             vs_n
);

  localparam int RW = $clog2(HS_WIDTH + 2);

  logic [RW-1:0] hs_run;
  int            line_len, field_two;

  always_comb begin
    line_len  = std_sel ? LINE_B : LINE_A;
    field_two = ((std_sel ? FRAME_B : FRAME_A) + 1) / 2;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)                         hs_run <= '0;
    else if (ofs_hi_we || ofs_lo_we || hs_n) hs_run <= '0;
    else if (pix_en)                         hs_run <= hs_run + RW'(1);
  end

  AST_HOLD_WITHOUT_ENABLE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !pix_en |=> ($stable(hcnt) && $stable(vcnt) && $stable(fld_q))); // R9

  AST_LINE_POS_RANGE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    int'(hcnt) < line_len); // R2

  AST_OFFSET_HOLD: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(ofs_hi_we || ofs_lo_we) |=> $stable(ofs_q)); // R5

  AST_FIELD_STEP_AT_START: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !$stable(fld_q) |-> ((vcnt == '0) || (int'(vcnt) == field_two))); // R7

  AST_VS_ON_FIRST_LINE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (master_en && (vcnt == '0)) |-> !vs_n); // R6

  AST_HS_NO_OVERLENGTH: assert property (@(posedge clk) disable iff (!rst_sync_n)
    int'(hs_run) <= HS_WIDTH); // R3

endmodule

bind mst_sync_gen mst_sync_chk #(
  .OFS_W    (OFS_W),
  .LINE_A   (LINE_A),
  .LINE_B   (LINE_B),
  .FRAME_A  (FRAME_A),
  .FRAME_B  (FRAME_B),
  .HS_WIDTH (HS_WIDTH),
  .FLD_W    (FLD_W),
  .HW       (HW),
  .VW       (VW)
) u_chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .pix_en     (pix_en),
  .master_en  (master_en),
  .std_sel    (std_sel),
  .ofs_hi_we  (ofs_hi_we),
  .ofs_lo_we  (ofs_lo_we),
  .ofs_q      (ofs_q),
  .hcnt       (hcnt),
  .vcnt       (vcnt),
  .fld_q      (fld_q),
  .hs_n       (hs_n),
  .vs_n       (vs_n)
);

// File: tb/tb_mst_sync_gen.sv
`timescale 1ns/1ps
module tb_mst_sync_gen;

  localparam int LA  = 858;
  localparam int LB  = 864;
  localparam int FA  = 9;
  localparam int FB  = 11;
  localparam int VSL = 2;
  localparam int HSW = 64;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pix_en = 1'b0;
  logic       master_en = 1'b1;
  logic       std_sel = 1'b0;
  logic       hi_we = 1'b0;
  logic       lo_we = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic       hs_n, vs_n;
  logic [2:0] fld;

  mst_sync_gen #(.FRAME_A(FA), .FRAME_B(FB), .VS_LINES(VSL)) dut (
    .clk(clk), .rst_n(rst_n), .pix_en(pix_en), .master_en(master_en),
    .std_sel(std_sel), .ofs_hi_we(hi_we), .ofs_lo_we(lo_we), .ofs_wdata(wdata),
    .hs_n(hs_n), .vs_n(vs_n), .fld(fld));

  always #2 clk = ~clk;

  int vectors = 0;
  int fails   = 0;
  bit done    = 1'b0;
  int m_h, m_v, m_f, m_ofs;
  int L, V, HALF, FMAX;

  task automatic check(string tag, int act, int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int hs_pos();
    return (m_ofs >= L) ? m_ofs - L : m_ofs;
  endfunction

  task automatic compare();
    int  p;
    bit  hact, vact;
    p    = hs_pos();
    hact = (m_h >= p) && (m_h < p + HSW);
    vact = (m_v < VSL) || ((m_v >= HALF) && (m_v < HALF + VSL));
    if (master_en) begin
      check((p + HSW > L && m_h >= p) ? "R4 truncated hs_n" : "R3 hs_n", int'(hs_n), int'(!hact));
      check("R6 vs_n", int'(vs_n), int'(!vact));
      check("R7 fld", int'(fld), m_f);
    end else begin
      check("R8 hs_n parked", int'(hs_n), 1);
      check("R8 vs_n parked", int'(vs_n), 1);
      check("R8 fld parked", int'(fld), 0);
    end
  endtask

  task automatic tick(bit en, bit hwe, bit lwe, logic [7:0] d);
    pix_en = en; hi_we = hwe; lo_we = lwe; wdata = d;
    @(posedge clk); #1;
    if (hwe) m_ofs = (m_ofs & 'hFF) | ((int'(d) & 3) << 8);
    if (lwe) m_ofs = (m_ofs & 'h300) | int'(d);
    if (en) begin
      if (m_h >= L - 1) begin
        m_h = 0;
        m_v = (m_v >= V - 1) ? 0 : m_v + 1;
        if (m_v == 0 || m_v == HALF) m_f = (m_f >= FMAX) ? 0 : m_f + 1;
      end else m_h++;
    end
    @(negedge clk);
    pix_en = 1'b0; hi_we = 1'b0; lo_we = 1'b0;
    compare();
  endtask

  task automatic do_reset(bit s);
    rst_n = 1'b0; std_sel = s; pix_en = 1'b0; hi_we = 1'b0; lo_we = 1'b0;
    master_en = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    m_h = 0; m_v = 0; m_f = 0; m_ofs = 'h07E;
    L = s ? LB : LA; V = s ? FB : FA; HALF = (V + 1) / 2; FMAX = s ? 7 : 3;
  endtask

  task automatic write_ofs(int v);
    tick(1'b0, 1'b1, 1'b0, 8'(v >> 8));
    tick(1'b0, 1'b0, 1'b1, 8'(v & 'hFF));
  endtask

  // enabled clocks from line start to hs_n falling
  task automatic meas_pos(output int n);
    while (m_h != L - 1) tick(1'b1, 1'b0, 1'b0, 8'h00);
    tick(1'b1, 1'b0, 1'b0, 8'h00);
    n = 0;
    while (hs_n == 1'b1 && n < 2000) begin tick(1'b1, 1'b0, 1'b0, 8'h00); n++; end
  endtask

  task automatic meas_width(output int w);
    w = 0;
    while (hs_n == 1'b0 && w < 2000) begin tick(1'b1, 1'b0, 1'b0, 8'h00); w++; end
  endtask

  task automatic directed(bit s);
    int n, w, r;
    r = s ? 137 : 126;
    do_reset(s);
    check("R1 hs_n after reset", int'(hs_n), 1);
    check("R1 vs_n after reset", int'(vs_n), 0);
    check("R1 fld after reset", int'(fld), 0);
    meas_pos(n);   check("R5 reset offset position", n, 126);
    meas_width(w); check("R3 nominal width", w, HSW);
    n = 0;
    while (hs_n == 1'b1 && n < 2000) begin tick(1'b1, 1'b0, 1'b0, 8'h00); n++; end
    check("R2 hs period", n + HSW, L);
    write_ofs(s ? 'h081 : 'h076);
    meas_pos(n);   check("R3 advance by 8", n, r - 8);
    meas_width(w); check("R3 width after advance", w, HSW);
    write_ofs(s ? 'h2BD : 'h2AC);
    meas_pos(n);   check("R3 advance by 300 wraps to previous line", n, r - 300 + L);
    write_ofs(L - 8);
    meas_pos(n);   check("R4 start near line end", n, L - 8);
    meas_width(w); check("R4 shortened width", w, 8);
    write_ofs(1023);
    meas_pos(n);   check("R3 offset above line length", n, 1023 - L);
    repeat (40) tick(1'b0, 1'b0, 1'b0, 8'h00);
    check("R9 hs_n held low without enable", int'(hs_n), 0);
    repeat (HSW - 1) tick(1'b1, 1'b0, 1'b0, 8'h00);
    check("R9 pulse resumes its count", int'(hs_n), 0);
    tick(1'b1, 1'b0, 1'b0, 8'h00);
    check("R9 pulse ends after 64 enabled clocks", int'(hs_n), 1);
    master_en = 1'b0; #1;
    check("R8 hs_n off", int'(hs_n), 1);
    check("R8 vs_n off", int'(vs_n), 1);
    check("R8 fld off", int'(fld), 0);
    repeat (300) tick(1'b1, 1'b0, 1'b0, 8'h00);
    master_en = 1'b1; #1;
    compare();
    while (!(m_v == HALF && m_h == 0)) tick(1'b1, 1'b0, 1'b0, 8'h00);
    check("R6 vs_n at field two start", int'(vs_n), 0);
    check("R7 fld at field two start", int'(fld), m_f);
    while (!(m_v == HALF + VSL && m_h == 0)) tick(1'b1, 1'b0, 1'b0, 8'h00);
    check("R6 vs_n after vertical interval", int'(vs_n), 1);
  endtask

  task automatic random_run(int cycles);
    for (int i = 0; i < cycles; i++) begin
      bit en, hw, lw;
      en = ($urandom_range(7) != 0);
      hw = ($urandom_range(799) == 0);
      lw = ($urandom_range(799) == 0);
      if ($urandom_range(2999) == 0) master_en = ~master_en;
      tick(en, hw, lw, 8'($urandom_range(255)));
    end
    master_en = 1'b1;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    directed(1'b0);
    random_run(52000);
    directed(1'b1);
    random_run(52000);
    if (!done) begin
      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    repeat (198000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      fails++;
      $display("FAIL watchdog (all requirements): actual %0d cycles expected fewer", 198000);
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

endmodule